// File: doc/BRIEF.md
# Guarded Program-Memory Write Controller

This block sits between a CPU's register bus and an on-chip nonvolatile program memory. It stops writes to that memory unless software proves its intent. Software loads a 22-bit memory pointer through three byte registers. It sets fields in a control register to pick the target space and the operation. It then writes two fixed key bytes, one after the other, to a key register that stores nothing. Only after that may it set the write-start bit. When the write is accepted, the block sends a one-cycle start pulse to the array and holds the CPU stalled until the array reports that it is done.

The block has two resets. The power-on reset clears everything. The warm reset, which stands for an external pin reset or a watchdog reset, clears everything except the write-error flag. If a warm reset arrives while a write is running, it sets that flag, so software can find out that the write was cut short and try it again.

Register map (byte address, read value): 0 control, 1 key (reads 0), 2 pointer bits 7:0, 3 pointer bits 15:8, 4 pointer bits 21:16 in bits 5:0. The warm reset acts on the clock edge. The power-on reset acts at once.

Top module: `nvm_write_guard`

## Requirements
- R1: After power-on reset, the control register and all pointer bytes read 0, and mem_start, cpu_stall and rd_pulse are low.
- R2: A control write at address 0 with bit 1 set is accepted as a write when three things hold: write-enable (bit 2) is already set, the last two key-register writes were 0x55 and then 0xAA, and no write is busy. The access right before it also counts. On acceptance, mem_start is high for exactly the one cycle after that write.
- R3: A write-start request while the stored write-enable bit is clear starts nothing, and bit 1 reads back 0.
- R4: A write-start request starts nothing if the key sequence is missing, incomplete, or broken by any other access to the key register (a read, or any value other than 0xAA after 0x55).
- R5: Every write-start request, whether accepted or not, uses up the key sequence. A second request needs a new sequence.
- R6: From the cycle after acceptance, cpu_stall is high and control bit 1 reads 1. Both stay that way until the cycle after mem_done is sampled high. Software writes cannot clear bit 1.
- R7: The key register and addresses 5 to 7 read 0. Control bit 5 and bits 7:6 of the upper pointer byte always read 0.
- R8: The three pointer bytes combine into mem_addr[21:0], with bits 21:16 from address 4, bits 15:8 from address 3 and bits 7:0 from address 2.
- R9: A warm reset while a write is busy sets the write-error flag (control bit 3). A warm reset clears every other field and drops cpu_stall, but leaves the flag unchanged.
- R10: Software clears the write-error flag by writing 0 to bit 3. Writing 1 to bit 3 does not set it.
- R11: Control bits 7 (memory select), 6 (config select) and 4 (erase) drive mem_sel, mem_cfg and mem_erase. While a write is busy, these bits and the pointer bytes ignore writes.
- R12: Writing 1 to control bit 0 while not busy produces a one-cycle rd_pulse, and the bit clears itself after that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, asynchronous, active low, clears all state |
| rst_n | input | 1 | Warm reset, synchronous, active low, keeps the error flag |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 3 | Register byte address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr |
| mem_done | input | 1 | Array reports the running write finished |
| mem_start | output | 1 | One-cycle write start pulse to the array |
| cpu_stall | output | 1 | CPU hold while a write is busy |
| rd_pulse | output | 1 | One-cycle read start pulse to the array |
| mem_sel | output | 1 | Program memory select |
| mem_cfg | output | 1 | Configuration space select |
| mem_erase | output | 1 | Erase instead of program |
| mem_addr | output | 22 | Memory pointer |

## Verification
The embedded assertions check, on every cycle, that a start pulse lasts one cycle and only follows an armed key state with write-enable set. They also check that the start pulse brings the stall with it, that the stall holds until done or a warm reset, that a warm reset during a busy write leaves the error flag set, and that read pulses last one cycle. Other behaviour shows only in the bench scenarios: a broken key sequence, a key sequence used up by an earlier request, bus fields frozen during a busy write, and the error flag surviving a second warm reset and then responding to software writes. A behavioural reference model is compared with the outputs on every clock.

// File: rtl/nvm_write_guard.sv
module nvm_write_guard #(
  parameter int          PTR_W = 22,
  parameter int          BA_W  = 3,
  parameter logic [7:0]  KEY_A = 8'h55,
  parameter logic [7:0]  KEY_B = 8'hAA
) (
  input  logic             clk,
  input  logic             por_n,
  input  logic             rst_n,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic [BA_W-1:0]  bus_addr,
  input  logic [7:0]       bus_wdata,
  output logic [7:0]       bus_rdata,
  input  logic             mem_done,
  output logic             mem_start,
  output logic             cpu_stall,
  output logic             rd_pulse,
  output logic             mem_sel,
  output logic             mem_cfg,
  output logic             mem_erase,
  output logic [PTR_W-1:0] mem_addr
);
  localparam int UP_W = PTR_W - 16;
  localparam logic [BA_W-1:0] A_CTRL = BA_W'(0);
  localparam logic [BA_W-1:0] A_KEY  = BA_W'(1);
  localparam logic [BA_W-1:0] A_PLO  = BA_W'(2);
  localparam logic [BA_W-1:0] A_PHI  = BA_W'(3);
  localparam logic [BA_W-1:0] A_PUP  = BA_W'(4);

  typedef enum logic [1:0] {S_IDLE, S_HALF, S_ARMED} key_t;

  key_t            st_q, st_d;
  logic            busy_q, start_q, rd_q, wren_q, werr_q;
  logic            sel_q, cfg_q, erase_q;
  logic [7:0]      plo_q, phi_q;
  logic [UP_W-1:0] pup_q;

  wire key_acc = (bus_wr || bus_rd) && bus_addr == A_KEY;
  wire ctrl_wr = bus_wr && bus_addr == A_CTRL;
  wire go      = ctrl_wr && bus_wdata[1] && st_q == S_ARMED && wren_q && !busy_q;
  wire open_wr = bus_wr && !busy_q;

  always_comb begin
    st_d = st_q;
    if (key_acc) begin
      if (bus_wr && bus_wdata == KEY_A)                     st_d = S_HALF;
      else if (bus_wr && bus_wdata == KEY_B && st_q == S_HALF) st_d = S_ARMED;
      else                                                  st_d = S_IDLE;
    end else if (ctrl_wr && bus_wdata[1]) begin
      st_d = S_IDLE;
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n || !rst_n) begin
      st_q <= S_IDLE;  busy_q <= 1'b0; start_q <= 1'b0; rd_q <= 1'b0;
      wren_q <= 1'b0;  sel_q <= 1'b0;  cfg_q <= 1'b0;   erase_q <= 1'b0;
      plo_q <= '0;     phi_q <= '0;    pup_q <= '0;
    end else begin
      st_q    <= st_d;
      start_q <= go;
      busy_q  <= go || (busy_q && !mem_done);
      rd_q    <= ctrl_wr && !busy_q && bus_wdata[0];
      if (ctrl_wr) wren_q <= bus_wdata[2];
      if (ctrl_wr && !busy_q) begin
        sel_q   <= bus_wdata[7];
        cfg_q   <= bus_wdata[6];
        erase_q <= bus_wdata[4];
      end
      if (open_wr && bus_addr == A_PLO) plo_q <= bus_wdata;
      if (open_wr && bus_addr == A_PHI) phi_q <= bus_wdata;
      if (open_wr && bus_addr == A_PUP) pup_q <= bus_wdata[UP_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)                       werr_q <= 1'b0;
    else if (!rst_n)                  werr_q <= werr_q || busy_q;
    else if (ctrl_wr && !bus_wdata[3]) werr_q <= 1'b0;
  end

  always_comb begin
    case (bus_addr)
      A_CTRL:  bus_rdata = {sel_q, cfg_q, 1'b0, erase_q, werr_q, wren_q, busy_q, rd_q};
      A_PLO:   bus_rdata = plo_q;
      A_PHI:   bus_rdata = phi_q;
      A_PUP:   bus_rdata = {{(8-UP_W){1'b0}}, pup_q};
      default: bus_rdata = 8'h00;
    endcase
  end

  assign mem_start = start_q;
  assign cpu_stall = busy_q;
  assign rd_pulse  = rd_q;
  assign mem_sel   = sel_q;
  assign mem_cfg   = cfg_q;
  assign mem_erase = erase_q;
  assign mem_addr  = {pup_q, phi_q, plo_q};

  p_start_one_cycle_r2: assert property (@(posedge clk) disable iff (!por_n)
    mem_start |=> !mem_start);
  p_start_needs_wren_r3: assert property (@(posedge clk) disable iff (!por_n)
    $rose(mem_start) |-> $past(wren_q));
  p_start_needs_keys_r4: assert property (@(posedge clk) disable iff (!por_n)
    $rose(mem_start) |-> $past(st_q) == S_ARMED);
  p_start_stalls_r6: assert property (@(posedge clk) disable iff (!por_n)
    mem_start |-> cpu_stall);
  p_stall_holds_r6: assert property (@(posedge clk) disable iff (!por_n)
    cpu_stall && !mem_done && rst_n |=> cpu_stall);
  p_werr_on_abort_r9: assert property (@(posedge clk) disable iff (!por_n)
    cpu_stall && !rst_n |=> werr_q);
  p_rd_one_cycle_r12: assert property (@(posedge clk) disable iff (!por_n)
    rd_pulse |=> !rd_pulse);
endmodule

// File: tb/tb_nvm_write_guard.sv
module tb_nvm_write_guard;
  logic clk = 0, por_n = 0, rst_n = 1, bus_wr = 0, bus_rd = 0, mem_done = 0;
  logic [2:0] bus_addr = 0;
  logic [7:0] bus_wdata = 0, bus_rdata;
  logic mem_start, cpu_stall, rd_pulse, mem_sel, mem_cfg, mem_erase;
  logic [21:0] mem_addr;
  int checks = 0, errors = 0, cyc = 0;

  always #4 clk = ~clk;

  nvm_write_guard dut (.clk(clk), .por_n(por_n), .rst_n(rst_n), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .mem_done(mem_done), .mem_start(mem_start), .cpu_stall(cpu_stall),
    .rd_pulse(rd_pulse), .mem_sel(mem_sel), .mem_cfg(mem_cfg),
    .mem_erase(mem_erase), .mem_addr(mem_addr));

  // behavioural reference model
  int m_state = 0, m_ptr = 0;
  bit m_sel, m_cfg, m_erase, m_werr, m_wren, m_busy, m_rd, m_start;

  always @(posedge clk) begin
    bit b_old; int s_old;
    b_old = m_busy; s_old = m_state;
    m_start = 0; m_rd = 0;
    if (!por_n || !rst_n) begin
      m_werr = !por_n ? 0 : (m_werr | b_old);
      m_state = 0; m_ptr = 0; m_sel = 0; m_cfg = 0; m_erase = 0; m_wren = 0; m_busy = 0;
    end else begin
      if (b_old && mem_done) m_busy = 0;
      if ((bus_wr || bus_rd) && bus_addr == 1) begin
        if (bus_wr && bus_wdata == 8'h55) m_state = 1;
        else if (bus_wr && bus_wdata == 8'hAA && s_old == 1) m_state = 2;
        else m_state = 0;
      end
      if (bus_wr && bus_addr == 0) begin
        if (bus_wdata[1]) begin
          if (s_old == 2 && m_wren && !b_old) begin m_busy = 1; m_start = 1; end
          m_state = 0;
        end
        if (!b_old) begin
          m_sel = bus_wdata[7]; m_cfg = bus_wdata[6]; m_erase = bus_wdata[4];
          m_rd = bus_wdata[0];
        end
        m_wren = bus_wdata[2];
        if (!bus_wdata[3]) m_werr = 0;
      end
      if (bus_wr && !b_old) begin
        if (bus_addr == 2) m_ptr = (m_ptr & 32'h3FFF00) | int'(bus_wdata);
        if (bus_addr == 3) m_ptr = (m_ptr & 32'h3F00FF) | (int'(bus_wdata) << 8);
        if (bus_addr == 4) m_ptr = (m_ptr & 32'h00FFFF) | (int'(bus_wdata & 8'h3F) << 16);
      end
    end
  end

  function automatic logic [7:0] m_rdata();
    case (bus_addr)
      0: return {m_sel, m_cfg, 1'b0, m_erase, m_werr, m_wren, m_busy, m_rd};
      2: return 8'(m_ptr);
      3: return 8'(m_ptr >> 8);
      4: return 8'(m_ptr >> 16);
      default: return 8'h00;
    endcase
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h at cycle %0d", req, act, exp, cyc);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (por_n) begin
      chk("R7 model rdata", bus_rdata, m_rdata());
      chk("R2 model start", mem_start, m_start);
      chk("R6 model stall", cpu_stall, m_busy);
      chk("R12 model rd", rd_pulse, m_rd);
      chk("R8 model addr", mem_addr, m_ptr);
      chk("R11 model fields", {mem_sel, mem_cfg, mem_erase}, {m_sel, m_cfg, m_erase});
    end
    if (cyc > 5000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(posedge clk); #2; bus_wr = 1; bus_rd = 0; bus_addr = a; bus_wdata = d;
  endtask
  task automatic idle();
    @(posedge clk); #2; bus_wr = 0; bus_rd = 0; mem_done = 0; rst_n = 1;
  endtask
  task automatic rd_chk(input logic [2:0] a, input logic [7:0] exp, input string req);
    @(posedge clk); #2; bus_wr = 0; bus_rd = 1; bus_addr = a;
    @(negedge clk); chk(req, bus_rdata, exp);
  endtask
  task automatic done_pulse();
    @(posedge clk); #2; bus_wr = 0; bus_rd = 0; mem_done = 1;
    idle();
  endtask
  task automatic warm_reset();
    @(posedge clk); #2; bus_wr = 0; bus_rd = 0; rst_n = 0;
    idle();
  endtask
  task automatic unlock();
    wr(1, 8'h55); wr(1, 8'hAA);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2 por_n = 1;
    @(negedge clk);
    chk("R1 stall", cpu_stall, 0); chk("R1 start", mem_start, 0); chk("R1 rd", rd_pulse, 0);
    rd_chk(0, 8'h00, "R1 ctrl"); rd_chk(4, 8'h00, "R1 ptr up");
    wr(4, 8'hFF); wr(3, 8'h12); wr(2, 8'h34); idle();
    @(negedge clk); chk("R8 mem_addr", mem_addr, 22'h3F1234);
    rd_chk(4, 8'h3F, "R7 ptr up bits"); rd_chk(5, 8'h00, "R7 unused addr");
    wr(0, 8'hF4); idle();
    rd_chk(0, 8'hD4, "R7 ctrl bit5");
    @(negedge clk); chk("R11 outputs", {mem_sel, mem_cfg, mem_erase}, 3'b111);
    wr(0, 8'h94); wr(0, 8'h96); idle();
    @(negedge clk); chk("R4 no keys", mem_start, 0);
    rd_chk(0, 8'h94, "R4 ctrl");
    wr(1, 8'h55); rd_chk(1, 8'h00, "R7 key reads 0");
    wr(1, 8'hAA); wr(0, 8'h96); idle();
    @(negedge clk); chk("R4 broken seq", mem_start, 0);
    wr(1, 8'h55); wr(1, 8'h12); wr(1, 8'hAA); wr(0, 8'h96); idle();
    @(negedge clk); chk("R4 wrong key", mem_start, 0);
    wr(0, 8'h90); unlock(); wr(0, 8'h92); idle();
    @(negedge clk); chk("R3 no wren", mem_start, 0);
    rd_chk(0, 8'h90, "R3 ctrl");
    wr(0, 8'h94); unlock(); wr(0, 8'h96); idle();
    @(negedge clk); chk("R2 start", mem_start, 1); chk("R6 stall", cpu_stall, 1);
    @(negedge clk); chk("R2 start one cycle", mem_start, 0);
    rd_chk(0, 8'h96, "R6 busy bit");
    wr(0, 8'h14); wr(2, 8'h00); idle();
    rd_chk(0, 8'h96, "R6 R11 ctrl held");
    @(negedge clk); chk("R11 ptr held", mem_addr, 22'h3F1234);
    chk("R6 stall held", cpu_stall, 1);
    done_pulse();
    @(negedge clk); chk("R6 stall drops", cpu_stall, 0);
    rd_chk(0, 8'h94, "R6 busy cleared");
    wr(0, 8'h96); idle();
    @(negedge clk); chk("R5 sequence used", mem_start, 0);
    wr(0, 8'h95); idle();
    @(negedge clk); chk("R12 rd pulse", rd_pulse, 1);
    @(negedge clk); chk("R12 rd clears", rd_pulse, 0);
    wr(0, 8'h94); unlock(); wr(0, 8'h96); idle();
    @(negedge clk); chk("R9 busy", cpu_stall, 1);
    warm_reset();
    @(negedge clk); chk("R9 stall cleared", cpu_stall, 0);
    rd_chk(0, 8'h08, "R9 werr set");
    rd_chk(4, 8'h00, "R9 ptr cleared");
    warm_reset();
    rd_chk(0, 8'h08, "R9 werr survives");
    wr(0, 8'h0C); idle();
    rd_chk(0, 8'h0C, "R10 write one keeps");
    wr(0, 8'h04); idle();
    rd_chk(0, 8'h04, "R10 clear");
    wr(0, 8'h08); idle();
    rd_chk(0, 8'h00, "R10 no software set");
    idle(); idle();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule